// File: doc/BRIEF.md
# Switch Controller Operating-Mode FSM

This block decides the operating mode of a four-channel output switch controller. Three condition flags come in from surrounding logic: a wake-up request, a fail flag (from a watchdog elsewhere) and a fault flag (from fault sensing elsewhere). The flags are registered, and the mode register then picks one of four modes by priority. A low wake-up request gives Sleep. Otherwise an active fault gives Fault. Otherwise an active fail gives Fail-safe. Otherwise the mode is Normal.

Around the mode register the block produces three things. The first is a status bit that is high in Normal. The second is a configuration clear that holds every programmable setting at zero while the controller sleeps. The third is one fault-reset control term per channel. That term is live only in Normal and Fail-safe, and it combines the channel's on request with its direct-input-disable bit.

Top module: `switch_mode_fsm`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `mode` is 2'b00 (Sleep), `cfg_clear` is 1, `normal_stat` is 0 and `fault_rst` is all zero.
- R2: When `wake_req` is 0, `mode` becomes 2'b00 (Sleep) whatever `fail_flag` and `fault_flag` are.
- R3: With `wake_req`=1, `fail_flag`=0 and `fault_flag`=0, `mode` becomes 2'b01 (Normal).
- R4: With `wake_req`=1, `fail_flag`=1 and `fault_flag`=0, `mode` becomes 2'b10 (Fail-safe).
- R5: With `wake_req`=1 and `fault_flag`=1, `mode` becomes 2'b11 (Fault) whatever `fail_flag` is.
- R6: A flag change shows on `mode` at the second rising clock edge after it is applied. The first edge loads the flag register and the second edge loads the mode register. `mode` is unchanged after only the first edge.
- R7: `normal_stat` is 1 exactly while `mode` is 2'b01.
- R8: `cfg_clear` is 1 exactly while `mode` is 2'b00. On leaving Sleep it falls in the same cycle that `mode` changes.
- R9: In Normal and Fail-safe, bit i of `fault_rst` equals `chan_in[i] & dir_dis[i]` for every channel i, and it follows those inputs without a clock delay.
- R10: In Sleep and Fault, `fault_rst` is all zero whatever `chan_in` and `dir_dis` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | 1 | Wake-up request |
| fail_flag | input | 1 | Fail condition flag |
| fault_flag | input | 1 | Fault condition flag |
| chan_in | input | NCH | Per-channel on request |
| dir_dis | input | NCH | Per-channel direct-input-disable bit |
| mode | output | 2 | Current mode: 00 Sleep, 01 Normal, 10 Fail-safe, 11 Fault |
| normal_stat | output | 1 | High in Normal |
| cfg_clear | output | 1 | Forces programmable configuration to zero in Sleep |
| fault_rst | output | NCH | Per-channel fault-reset control term |

## Verification
Every cycle, the assertions check that the registered flags pick the mode in the following cycle by the stated priority. They also check that the configuration clear excludes both the status bit and any fault-reset term, and that no fault-reset bit is set unless the matching request and disable bits are set. Only the bench's scenarios can show the exact two-edge latency, which needs the unchanged mode after the first edge to be observed. The same holds for the per-channel fault-reset values in each mode and for the asynchronous return to Sleep on a reset in the middle of a run.

// File: rtl/switch_mode_fsm.sv
module switch_mode_fsm #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wake_req,
  input  logic           fail_flag,
  input  logic           fault_flag,
  input  logic [NCH-1:0] chan_in,
  input  logic [NCH-1:0] dir_dis,
  output logic [1:0]     mode,
  output logic           normal_stat,
  output logic           cfg_clear,
  output logic [NCH-1:0] fault_rst
);

  localparam logic [1:0] M_SLEEP = 2'b00;
  localparam logic [1:0] M_NORM  = 2'b01;
  localparam logic [1:0] M_SAFE  = 2'b10;
  localparam logic [1:0] M_FAULT = 2'b11;

  logic wake_q, fail_q, fault_q;
  logic [1:0] mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q  <= 1'b0;
      fail_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      wake_q  <= wake_req;
      fail_q  <= fail_flag;
      fault_q <= fault_flag;
    end
  end

  always_comb begin
    if (!wake_q)      mode_d = M_SLEEP;
    else if (fault_q) mode_d = M_FAULT;
    else if (fail_q)  mode_d = M_SAFE;
    else              mode_d = M_NORM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= M_SLEEP;
    else        mode <= mode_d;
  end

  assign normal_stat = (mode == M_NORM);
  assign cfg_clear   = (mode == M_SLEEP);
  assign fault_rst   = (mode == M_NORM || mode == M_SAFE) ? (chan_in & dir_dis) : '0;

  // R2
  sleep_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_q |=> mode == M_SLEEP);
  // R3
  normal_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && !fail_q && !fault_q) |=> mode == M_NORM);
  // R4
  safe_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && fail_q && !fault_q) |=> mode == M_SAFE);
  // R5
  fault_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && fault_q) |=> mode == M_FAULT);
  // R8
  clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |-> (!normal_stat && fault_rst == '0));
  // R9
  frst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_rst & ~(chan_in & dir_dis)) == '0);

endmodule

// File: tb/switch_mode_fsm_bench.sv
`timescale 1ns/1ps
module switch_mode_fsm_bench;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0;
  logic wake_req = 0, fail_flag = 0, fault_flag = 0;
  logic [NCH-1:0] chan_in = '0, dir_dis = '0;
  logic [1:0] mode;
  logic normal_stat, cfg_clear;
  logic [NCH-1:0] fault_rst;
  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  switch_mode_fsm #(.NCH(NCH)) u_switch_mode_fsm (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .fail_flag(fail_flag),
    .fault_flag(fault_flag), .chan_in(chan_in), .dir_dis(dir_dis),
    .mode(mode), .normal_stat(normal_stat), .cfg_clear(cfg_clear),
    .fault_rst(fault_rst));

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(logic w, logic f, logic t);
    if (!w) return 2'b00;
    if (t)  return 2'b11;
    if (f)  return 2'b10;
    return 2'b01;
  endfunction

  task automatic apply(logic w, logic f, logic t);
    @(negedge clk);
    wake_req = w; fail_flag = f; fault_flag = t;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 mode", {6'd0, mode}, 8'h00);
    check("R1 cfg_clear", {7'd0, cfg_clear}, 8'h01);
    check("R1 normal_stat", {7'd0, normal_stat}, 8'h00);
    check("R1 fault_rst", {4'd0, fault_rst}, 8'h00);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 mode after release", {6'd0, mode}, 8'h00);
  endtask

  task automatic t_all_combos();
    for (int v = 0; v < 8; v++) begin
      logic [1:0] e;
      apply(v[2], v[1], v[0]);
      e = exp_mode(v[2], v[1], v[0]);
      if (!v[2])               check("R2 sleep", {6'd0, mode}, {6'd0, e});
      else if (v[0])           check("R5 fault", {6'd0, mode}, {6'd0, e});
      else if (v[1])           check("R4 failsafe", {6'd0, mode}, {6'd0, e});
      else                     check("R3 normal", {6'd0, mode}, {6'd0, e});
      check("R7 normal_stat", {7'd0, normal_stat}, {7'd0, e == 2'b01});
      check("R8 cfg_clear", {7'd0, cfg_clear}, {7'd0, e == 2'b00});
    end
  endtask

  task automatic t_latency();
    apply(0, 0, 0);
    @(negedge clk); wake_req = 1;
    @(posedge clk); @(negedge clk);
    check("R6 unchanged after one edge", {6'd0, mode}, 8'h00);
    check("R8 clear held after one edge", {7'd0, cfg_clear}, 8'h01);
    @(posedge clk); @(negedge clk);
    check("R6 changed after two edges", {6'd0, mode}, 8'h01);
    check("R8 clear released with mode", {7'd0, cfg_clear}, 8'h00);
  endtask

  task automatic t_fault_rst();
    apply(1, 0, 0);
    chan_in = 4'b1011; dir_dis = 4'b0110; #1;
    check("R9 normal", {4'd0, fault_rst}, 8'h02);
    chan_in = 4'b1111; dir_dis = 4'b1001; #1;
    check("R9 normal comb", {4'd0, fault_rst}, 8'h09);
    apply(1, 1, 0);
    chan_in = 4'b0101; dir_dis = 4'b1111; #1;
    check("R9 failsafe", {4'd0, fault_rst}, 8'h05);
    chan_in = 4'b1111; dir_dis = 4'b1111;
    apply(1, 1, 1);
    check("R10 fault", {4'd0, fault_rst}, 8'h00);
    apply(0, 1, 0);
    check("R10 sleep", {4'd0, fault_rst}, 8'h00);
  endtask

  task automatic t_mid_reset();
    apply(1, 0, 0);
    check("R3 before reset", {6'd0, mode}, 8'h01);
    rst_n = 0; #1;
    check("R1 async reset mode", {6'd0, mode}, 8'h00);
    check("R1 async reset clear", {7'd0, cfg_clear}, 8'h01);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #3;
    t_reset();
    t_all_combos();
    t_latency();
    t_fault_rst();
    t_mid_reset();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule